// File: doc/BRIEF.md
# Write-Protect Control Register Unit

This unit holds the protection register of a serial EEPROM and enforces its write policy. It sits behind a byte-level two-wire slave front end. The front end decodes bus start and stop conditions, delivers each received data byte with the current 16-bit word address, and raises a read request when the master asks for data. For every written byte the unit decides whether it is acknowledged. For array bytes it also says whether the byte may be written. For register bytes it records a pending operation that only takes effect when the stop condition arrives.

The register is reached through the all-ones word address. Two volatile enable latches gate all writes. The first is the global write enable, which is set by the byte 8'h02. The second is the register write enable, which is set by the byte 8'h06. A third register write then commits the protect-enable bit and the three block-protect bits. That commit starts a modelled nonvolatile programming interval of `BUSY_CYC` cycles, during which no byte is acknowledged. A read of the register returns one byte and tells the front end to zero its address counter. The same happens when programming ends.

The front end is assumed to raise at most one event per cycle.

Top module: `wp_ctrl_unit`

## Requirements
- R1: After reset, wel_o, rwel_o, wpen_o, bp_o and busy_o are all 0, and a register read returns 8'h00.
- R2: While the write enable is 0, every written byte gets wr_ack_o=0 and array_we_o=0, one cycle after wr_byte_i. The one exception is byte 8'h02 at address 16'hFFFF.
- R3: Byte 8'h02 written to 16'hFFFF, followed by a stop, sets wel_o in the cycle after the stop.
- R4: Byte 8'h06 written to 16'hFFFF while wel=1 and rwel=0, followed by a stop, sets rwel_o.
- R5: Within one transaction, only the first register byte can be acknowledged. Later register bytes get wr_ack_o=0 and have no effect.
- R6: A register byte has no effect before the stop. A start arriving before the stop discards it.
- R7: While rwel=1, a byte with bit2=0 and bit1=1, followed by a stop, commits. busy_o is 1 for exactly BUSY_CYC cycles. In the cycle busy_o falls, wpen_o takes bit7 and bp_o[2:0] takes {bit0, bit4, bit3}, wel_o and rwel_o become 0, and addr_zero_o pulses.
- R8: While rwel=1, a byte with bit2=1 and bit1=1 aborts at the stop. rwel clears, wel stays 1, and the protect bits are unchanged.
- R9: A register byte with bit1=0, written while wel=1, clears both wel and rwel at the stop.
- R10: While busy_o is 1, no byte is acknowledged and read requests give rd_hit_o=0.
- R11: One cycle after a read request at 16'hFFFF, rd_hit_o=1, addr_zero_o=1 and rd_data_o={wpen,0,0,bp1,bp0,rwel,wel,bp2}. A read request at any other address gives rd_hit_o=0 and addr_zero_o=0.
- R12: With wel=1 and the unit not busy, an array byte gets wr_ack_o=1 and array_we_o=1. A register byte that matches no operation (bit1=1, rwel=0, not 8'h02 or 8'h06) is acknowledged and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Bus start (or repeated start) event |
| stop_i | input | 1 | Bus stop event |
| wr_byte_i | input | 1 | A data byte was received |
| wr_data_i | input | 8 | Received data byte |
| rd_req_i | input | 1 | Master requests a read byte |
| addr_i | input | AW | Current word address |
| wr_ack_o | output | 1 | Acknowledge for the last received byte |
| array_we_o | output | 1 | Last byte may be written to the array |
| rd_hit_o | output | 1 | Read served from the register |
| rd_data_o | output | 8 | Register value for a register read |
| addr_zero_o | output | 1 | Force the shared address counter to zero |
| busy_o | output | 1 | Nonvolatile programming in progress |
| wel_o | output | 1 | Write enable latch |
| rwel_o | output | 1 | Register write enable latch |
| wpen_o | output | 1 | Committed protect-enable bit |
| bp_o | output | 3 | Committed block-protect code {bp2,bp1,bp0} |

## Verification
Acknowledge, array write enable, read hit and read data all appear one cycle after the event that causes them. Latch changes become visible one cycle after the stop. Programming ends exactly BUSY_CYC cycles after the stop, and the new protect bits and the address-zero pulse appear in that same cycle. The bench drives each event on a falling edge, holds it for one cycle and samples on the next falling edge, so every sample falls after the single register stage. During programming it samples every cycle and requires busy high for exactly the configured count, then low together with the committed state.

// File: rtl/wpc_pkg.sv
// Shared types and constants for the write-protect control register unit.
package wpc_pkg;

    // Register operations recorded from an acknowledged register byte.
    typedef enum logic [2:0] {
        OP_NOP,
        OP_CLR,
        OP_SETWEL,
        OP_SETRWEL,
        OP_ABORT,
        OP_COMMIT
    } reg_op_e;

    // Bit positions inside the register byte (fixed: the master decodes them).
    localparam int unsigned B_WPEN = 7;
    localparam int unsigned B_BP1  = 4;
    localparam int unsigned B_BP0  = 3;
    localparam int unsigned B_RWEL = 2;
    localparam int unsigned B_WEL  = 1;
    localparam int unsigned B_BP2  = 0;

    localparam logic [7:0] EN_WEL_BYTE  = 8'h02;
    localparam logic [7:0] EN_BOTH_BYTE = 8'h06;

    // Committed protection fields.
    typedef struct packed {
        logic wpen;
        logic bp2;
        logic bp1;
        logic bp0;
    } prot_t;

    // Pull the protection fields out of a written byte.
    function automatic prot_t prot_from_byte(input logic [7:0] b);
        prot_t p;
        p.wpen = b[B_WPEN];
        p.bp2  = b[B_BP2];
        p.bp1  = b[B_BP1];
        p.bp0  = b[B_BP0];
        return p;
    endfunction

    // Assemble the readable register byte.
    function automatic logic [7:0] reg_byte(input prot_t p, input logic wel, input logic rwel);
        logic [7:0] b;
        b         = 8'h00;
        b[B_WPEN] = p.wpen;
        b[B_BP1]  = p.bp1;
        b[B_BP0]  = p.bp0;
        b[B_RWEL] = rwel;
        b[B_WEL]  = wel;
        b[B_BP2]  = p.bp2;
        return b;
    endfunction

endpackage

// File: rtl/wpc_decode.sv
// Byte classifier: decides the acknowledge for a received byte and, for a
// register byte, which register operation it requests.
// Assumes the caller qualifies the outputs with the byte-valid strobe.
module wpc_decode
    import wpc_pkg::*;
(
    input  logic       is_reg,
    input  logic [7:0] data,
    input  logic       wel,
    input  logic       rwel,
    input  logic       busy,
    input  logic       taken,
    output logic       ack,
    output reg_op_e    op
);

    // Acknowledge policy: never when busy, one register byte per transaction.
    always_comb begin
        if (busy) begin
            ack = 1'b0;
        end else if (is_reg) begin
            ack = !taken && (wel || (data == EN_WEL_BYTE));
        end else begin
            ack = wel;
        end
    end

    // Operation selection from the byte pattern and the current latch state.
    always_comb begin
        if (!data[B_WEL]) begin
            op = OP_CLR;
        end else if (rwel) begin
            op = data[B_RWEL] ? OP_ABORT : OP_COMMIT;
        end else if (data == EN_WEL_BYTE) begin
            op = OP_SETWEL;
        end else if (data == EN_BOTH_BYTE) begin
            op = OP_SETRWEL;
        end else begin
            op = OP_NOP;
        end
    end

endmodule

// File: rtl/wpc_txn.sv
// Transaction tracker: remembers whether a register byte was already taken in
// the current transaction and holds the pending operation until the stop.
// Assumes start, stop and byte strobes are never raised in the same cycle.
module wpc_txn
    import wpc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    start,
    input  logic    stop,
    input  logic    reg_take,
    input  reg_op_e op_in,
    input  prot_t   prot_in,
    output logic    taken,
    output logic    apply,
    output reg_op_e pend_op,
    output prot_t   pend_prot
);

    logic pend_valid;

    // Capture the first acknowledged register byte; clear on start or stop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken      <= 1'b0;
            pend_valid <= 1'b0;
            pend_op    <= OP_NOP;
            pend_prot  <= '0;
        end else if (start || stop) begin
            taken      <= 1'b0;
            pend_valid <= 1'b0;
        end else if (reg_take) begin
            taken      <= 1'b1;
            pend_valid <= 1'b1;
            pend_op    <= op_in;
            pend_prot  <= prot_in;
        end
    end

    // The pending operation fires on the stop.
    assign apply = stop && pend_valid;

    // R5: a taken transaction never records a second register byte.
    a_r5_single_take: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !start && !stop) |=> taken && $stable(pend_op));

    // R6: a start drops anything pending.
    a_r6_start_drops: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !taken);

endmodule

// File: rtl/wpc_busy.sv
// Programming timer: counts the modelled nonvolatile write interval.
// Assumes CYC >= 1 and that a new start only arrives while idle.
module wpc_busy #(
    parameter int unsigned CYC = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic done
);

    localparam int unsigned CW = $clog2(CYC + 1);

    logic [CW-1:0] cnt;

    // Load on go, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (go) begin
            cnt <= CW'(CYC);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1));

    // R7: programming begins in the cycle after go.
    a_r7_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> busy);

    // R7: busy cannot drop before the final count.
    a_r7_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

endmodule

// File: rtl/wpc_state.sv
// Latch and protect-bit store: holds the two volatile enable latches, the
// staged commit value and the committed protection fields.
// Assumes apply is a single-cycle strobe and done follows a commit.
module wpc_state
    import wpc_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    apply,
    input  reg_op_e op,
    input  prot_t   prot_in,
    input  logic    done,
    output logic    wel,
    output logic    rwel,
    output prot_t   prot,
    output logic    commit_go
);

    prot_t stage;

    assign commit_go = apply && (op == OP_COMMIT);

    // Volatile latch updates on stop and at the end of programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
        end else if (done) begin
            wel  <= 1'b0;
            rwel <= 1'b0;
        end else if (apply) begin
            unique case (op)
                OP_CLR:     begin wel <= 1'b0; rwel <= 1'b0; end
                OP_SETWEL:  wel  <= 1'b1;
                OP_SETRWEL: rwel <= 1'b1;
                OP_ABORT:   rwel <= 1'b0;
                default:    ;
            endcase
        end
    end

    // Stage the commit value on stop; copy it to the committed bits when done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage <= '0;
            prot  <= '0;
        end else begin
            if (commit_go) begin
                stage <= prot_in;
            end
            if (done) begin
                prot <= stage;
            end
        end
    end

    // R7: the end of programming clears both latches.
    a_r7_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!wel && !rwel));

    // R9: a clear byte drops both latches.
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && op == OP_CLR) |=> (!wel && !rwel));

    // R3: the enable byte sets the write enable.
    a_r3_set_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && op == OP_SETWEL && !done) |=> wel);

    // R8: an abort leaves the committed bits alone.
    a_r8_abort_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (apply && op == OP_ABORT && !done) |=> ($stable(prot) && !rwel));

endmodule

// File: rtl/wp_ctrl_unit.sv
// Write-protect control register unit: top level. Classifies each received
// byte, tracks the transaction, updates the enable latches and protect bits,
// runs the programming timer and serves register reads.
// Assumes the front end raises at most one event per cycle.
module wp_ctrl_unit
    import wpc_pkg::*;
#(
    parameter int unsigned AW       = 16,
    parameter int unsigned BUSY_CYC = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          stop_i,
    input  logic          wr_byte_i,
    input  logic [7:0]    wr_data_i,
    input  logic          rd_req_i,
    input  logic [AW-1:0] addr_i,
    output logic          wr_ack_o,
    output logic          array_we_o,
    output logic          rd_hit_o,
    output logic [7:0]    rd_data_o,
    output logic          addr_zero_o,
    output logic          busy_o,
    output logic          wel_o,
    output logic          rwel_o,
    output logic          wpen_o,
    output logic [2:0]    bp_o
);

    localparam logic [AW-1:0] REG_ADDR = '1;

    logic    is_reg;
    logic    dec_ack;
    reg_op_e dec_op;
    logic    taken;
    logic    apply;
    reg_op_e pend_op;
    prot_t   pend_prot;
    logic    wel;
    logic    rwel;
    prot_t   prot;
    logic    commit_go;
    logic    busy;
    logic    done;
    logic    reg_take;
    logic    rd_take;

    assign is_reg   = (addr_i == REG_ADDR);
    assign reg_take = wr_byte_i && is_reg && dec_ack;
    assign rd_take  = rd_req_i && is_reg && !busy;

    wpc_decode i_decode (
        .is_reg (is_reg),
        .data   (wr_data_i),
        .wel    (wel),
        .rwel   (rwel),
        .busy   (busy),
        .taken  (taken),
        .ack    (dec_ack),
        .op     (dec_op)
    );

    wpc_txn i_txn (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_i),
        .stop      (stop_i),
        .reg_take  (reg_take),
        .op_in     (dec_op),
        .prot_in   (prot_from_byte(wr_data_i)),
        .taken     (taken),
        .apply     (apply),
        .pend_op   (pend_op),
        .pend_prot (pend_prot)
    );

    wpc_state i_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .apply     (apply),
        .op        (pend_op),
        .prot_in   (pend_prot),
        .done      (done),
        .wel       (wel),
        .rwel      (rwel),
        .prot      (prot),
        .commit_go (commit_go)
    );

    wpc_busy #(.CYC(BUSY_CYC)) i_busy (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (commit_go),
        .busy  (busy),
        .done  (done)
    );

    // Register the per-event responses to the front end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ack_o    <= 1'b0;
            array_we_o  <= 1'b0;
            rd_hit_o    <= 1'b0;
            rd_data_o   <= 8'h00;
            addr_zero_o <= 1'b0;
        end else begin
            wr_ack_o    <= wr_byte_i && dec_ack;
            array_we_o  <= wr_byte_i && dec_ack && !is_reg;
            rd_hit_o    <= rd_take;
            rd_data_o   <= rd_take ? reg_byte(prot, wel, rwel) : 8'h00;
            addr_zero_o <= rd_take || done;
        end
    end

    assign busy_o = busy;
    assign wel_o  = wel;
    assign rwel_o = rwel;
    assign wpen_o = prot.wpen;
    assign bp_o   = {prot.bp2, prot.bp1, prot.bp0};

    // R2: no acknowledge without the write enable, except the enable byte.
    a_r2_no_ack_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_i && !wel && !(is_reg && wr_data_i == EN_WEL_BYTE)) |=> !wr_ack_o);

    // R10: nothing is acknowledged while programming.
    a_r10_busy_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_i && busy) |=> (!wr_ack_o && !array_we_o));

    // R10: reads are not served while programming.
    a_r10_busy_noread: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && busy) |=> !rd_hit_o);

    // R11: a register read always zeroes the address counter.
    a_r11_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit_o |-> addr_zero_o);

    // R5: a second register byte in one transaction is refused.
    a_r5_second_nack: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_byte_i && is_reg && taken) |=> !wr_ack_o);

endmodule

// File: tb/test_wp_ctrl_unit.sv
module test_wp_ctrl_unit;

    localparam int unsigned AW = 16;
    localparam int unsigned NB = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, stop_i = 1'b0, wr_byte_i = 1'b0, rd_req_i = 1'b0;
    logic [7:0]    wr_data_i = 8'h00;
    logic [AW-1:0] addr_i = '0;
    logic          wr_ack_o, array_we_o, rd_hit_o, addr_zero_o, busy_o, wel_o, rwel_o, wpen_o;
    logic [7:0]    rd_data_o;
    logic [2:0]    bp_o;

    wp_ctrl_unit #(.AW(AW), .BUSY_CYC(NB)) i_wp_ctrl_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .wr_byte_i(wr_byte_i), .wr_data_i(wr_data_i), .rd_req_i(rd_req_i),
        .addr_i(addr_i), .wr_ack_o(wr_ack_o), .array_we_o(array_we_o),
        .rd_hit_o(rd_hit_o), .rd_data_o(rd_data_o), .addr_zero_o(addr_zero_o),
        .busy_o(busy_o), .wel_o(wel_o), .rwel_o(rwel_o), .wpen_o(wpen_o), .bp_o(bp_o)
    );

    always #2.5 clk = ~clk;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;

    // Reference model state
    logic       m_wel, m_rwel, m_taken, m_pend;
    logic [7:0] m_pbyte;
    logic [3:0] m_prot;   // {wpen,bp2,bp1,bp0}

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_reg();
        return {m_prot[3], 2'b00, m_prot[1], m_prot[0], m_rwel, m_wel, m_prot[2]};
    endfunction

    function automatic logic exp_ack(input logic isreg, input logic [7:0] d);
        if (isreg) return !m_taken && (m_wel || d == 8'h02);
        return m_wel;
    endfunction

    task automatic chk_state(input string req);
        check(req, {wel_o, rwel_o, wpen_o, bp_o}, {m_wel, m_rwel, m_prot});
    endtask

    task automatic ev_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        m_taken = 0; m_pend = 0;
    endtask

    task automatic wbyte(input string req, input logic [AW-1:0] a, input logic [7:0] d, input logic in_busy);
        logic isreg, ea;
        isreg = (a == '1);
        ea = in_busy ? 1'b0 : exp_ack(isreg, d);
        @(negedge clk) begin wr_byte_i = 1'b1; addr_i = a; wr_data_i = d; end
        @(negedge clk) wr_byte_i = 1'b0;
        check(req, {wr_ack_o, array_we_o}, {ea, ea && !isreg});
        if (ea && isreg) begin m_taken = 1; m_pend = 1; m_pbyte = d; end
    endtask

    task automatic rdreq(input string req, input logic [AW-1:0] a, input logic in_busy);
        logic hit;
        logic [7:0] ev;
        hit = (a == '1) && !in_busy;
        ev = exp_reg();
        @(negedge clk) begin rd_req_i = 1'b1; addr_i = a; end
        @(negedge clk) rd_req_i = 1'b0;
        check(req, {rd_hit_o, addr_zero_o, rd_data_o}, {hit, hit, hit ? ev : 8'h00});
    endtask

    // Stop; poke=1 sends a byte and a read during programming.
    task automatic ev_stop(input string req, input bit poke);
        logic commit;
        logic [7:0] d;
        commit = 0;
        d = m_pbyte;
        if (m_pend) begin
            if (!d[1]) begin m_wel = 0; m_rwel = 0; end
            else if (m_rwel) begin
                if (d[2]) m_rwel = 0; else commit = 1;
            end
            else if (d == 8'h02) m_wel = 1;
            else if (d == 8'h06) m_rwel = 1;
        end
        m_taken = 0; m_pend = 0;
        @(negedge clk) stop_i = 1'b1;
        @(negedge clk) stop_i = 1'b0;
        check(req, {busy_o}, {commit});
        chk_state(req);
        if (commit) begin
            if (poke) begin
                wbyte("R10", $urandom_range(0, 16'hFFFE), $urandom, 1'b1);
                rdreq("R10", 16'hFFFF, 1'b1);
                for (int i = 0; i < 4 * NB && busy_o; i++) @(negedge clk);
                check("R7", {busy_o, addr_zero_o}, 2'b01);
            end else begin
                int hi;
                hi = 1;
                for (int i = 1; i < NB; i++) begin
                    @(negedge clk);
                    if (busy_o) hi++;
                end
                @(negedge clk);
                check("R7 busy length", hi, NB);
                check("R7 end", {busy_o, addr_zero_o}, 2'b01);
            end
            m_prot = {d[7], d[0], d[4], d[3]};
            m_wel = 0; m_rwel = 0;
            chk_state("R7");
        end
    endtask

    task automatic reg_txn(input string req, input logic [7:0] d, input bit poke);
        ev_start();
        wbyte(req, 16'hFFFF, d, 1'b0);
        ev_stop(req, poke);
    endtask

    initial begin
        m_wel = 0; m_rwel = 0; m_taken = 0; m_pend = 0; m_pbyte = 0; m_prot = 0;
        void'($urandom(32'h1F2E3D4C));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", {wel_o, rwel_o, wpen_o, bp_o, busy_o}, 7'b0);
        rdreq("R1 R11", 16'hFFFF, 1'b0);
        rdreq("R11 other addr", 16'h0040, 1'b0);
        // locked
        ev_start();
        wbyte("R2 array", 16'h1234, 8'hA5, 1'b0);
        wbyte("R2 reg", 16'hFFFF, 8'h06, 1'b0);
        ev_stop("R2", 0);
        // enable, pending only at stop, one byte per transaction
        ev_start();
        wbyte("R3", 16'hFFFF, 8'h02, 1'b0);
        check("R6 before stop", wel_o, 1'b0);
        wbyte("R5", 16'hFFFF, 8'h02, 1'b0);
        ev_stop("R3", 0);
        check("R3", wel_o, 1'b1);
        // repeated start discards
        ev_start();
        wbyte("R6", 16'hFFFF, 8'h00, 1'b0);
        ev_start();
        ev_stop("R6", 0);
        check("R6 discard", wel_o, 1'b1);
        // array and no-op register bytes
        ev_start();
        wbyte("R12 array", 16'h0100, 8'h3C, 1'b0);
        wbyte("R12 nop", 16'hFFFF, 8'hFA, 1'b0);
        ev_stop("R12", 0);
        rdreq("R12 R11", 16'hFFFF, 1'b0);
        reg_txn("R4", 8'h06, 0);
        check("R4", rwel_o, 1'b1);
        reg_txn("R8", 8'h8E, 0);
        check("R8", {wel_o, rwel_o}, 2'b10);
        reg_txn("R4", 8'h06, 0);
        reg_txn("R7", 8'h93, 0);
        rdreq("R7 R11", 16'hFFFF, 1'b0);
        reg_txn("R3", 8'h02, 0);
        reg_txn("R4", 8'h06, 0);
        reg_txn("R10", 8'h0A, 1);
        reg_txn("R3", 8'h02, 0);
        reg_txn("R9", 8'h00, 0);
        reg_txn("R3", 8'h02, 0);
        reg_txn("R4", 8'h06, 0);
        reg_txn("R9", 8'h04, 0);
        // random traffic
        for (int it = 0; it < 400; it++) begin
            int kind;
            kind = $urandom_range(0, 9);
            if (kind == 0) begin
                rdreq("R11 rand", ($urandom_range(0, 1) != 0) ? 16'hFFFF : 16'($urandom_range(0, 16'hFFFE)), 1'b0);
            end else begin
                int nb;
                nb = $urandom_range(1, 3);
                ev_start();
                for (int j = 0; j < nb; j++) begin
                    logic [7:0] d;
                    int pick;
                    pick = $urandom_range(0, 4);
                    d = (pick == 0) ? 8'h02 : (pick == 1) ? 8'h06 :
                        (pick == 2) ? ((8'($urandom) & 8'hF9) | 8'h02) : 8'($urandom);
                    if ($urandom_range(0, 2) != 0) wbyte("R5 rand", 16'hFFFF, d, 1'b0);
                    else wbyte("R12 rand", 16'($urandom_range(0, 16'hFFFE)), d, 1'b0);
                end
                if ($urandom_range(0, 9) == 0) ev_start();
                ev_stop("R7 rand", $urandom_range(0, 1));
            end
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule